// File: doc/BRIEF.md
# Mode-Selectable Raw Sample Capture Buffer

This block sits after the deserializer of a multi-channel sampling front end. On every sample tick it receives one wide word with the current sample of every channel, plus the state of the signal-switching reference. A mode input decides what is kept. In snapshot mode, a fixed number of consecutive ticks of all channels are written into one buffer. Capture then stops and a done flag is raised, so every channel can be tested for noise, linearity and crosstalk. In stream mode, one four-channel receiver group is chosen. Its samples, tagged with the switching bit, flow into two alternating half-buffers. A host reads one half while the other fills, which gives a continuous raw record for tuning the demodulation timing. In off mode nothing is written.

A small read port gives the host access to both buffers and to a status word. The host frees a full half by pulsing an acknowledge input.

Top module: `raw_capture_buf`

## Requirements
- R1: After reset, the status word reads 0 and `rd_valid` is low.
- R2: When `mode` is 0 (off) or 3 (reserved), a tick writes nothing. Snapshot buffer contents are unchanged and the status word reads 0.
- R3: When `mode` is 1 (snapshot), tick k (counted from entry into the mode) stores all channels in snapshot row k. After SNAP_TICKS ticks, status bit 0 (done) is set and further ticks change nothing. A snapshot read at row r, column c returns channel c of row r in `rd_data[SW-1:0]`.
- R4: Leaving snapshot mode clears done. Re-entering it restarts capture at row 0.
- R5: When `mode` is 2 (stream), each tick stores the channels 4·n to 4·n+3, where n = `rx_sel`, plus `sw_state`, as one entry. Entries are stored at consecutive positions of the active half. A stream read at row h·HALF_DEPTH+i with lane l (`rd_col` low two bits) returns channel 4·n+l in `rd_data[SW-1:0]` and the tag in `rd_data[SW]`.
- R6: When a half receives its last entry, its ready flag is set (status bit 1 for half 0, bit 2 for half 1). Writing then moves to the other half, and status bit 4 shows the half now being filled. A pulse on `ack_half[h]` clears ready flag h.
- R7: A tick whose target half still has its ready flag set is dropped. The overrun flag (status bit 3) is set, and the write position stays put. Writing resumes there once the half has been acknowledged.
- R8: The overrun flag stays set until a pulse on `ack_ovr`.
- R9: A read request sampled at one clock edge yields `rd_valid` high with the data two edges later. `rd_space` selects 0 for status, 1 for snapshot and 2 for stream.
- R10: Leaving stream mode clears both ready flags, the overrun flag and the write position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 off, 1 snapshot, 2 stream, 3 reserved (off) |
| rx_sel | input | RX_W | Receiver group select for stream mode |
| tick | input | 1 | One-cycle sample strobe |
| samples | input | NCH·SW | All channel samples, channel c at bits c·SW upward |
| sw_state | input | 1 | Switching reference state at this tick |
| ack_half | input | 2 | Pulse to clear ready flag of half 0 / half 1 |
| ack_ovr | input | 1 | Pulse to clear the overrun flag |
| rd_req | input | 1 | Read request |
| rd_space | input | 2 | Read target: 0 status, 1 snapshot, 2 stream |
| rd_row | input | ROW_W | Snapshot row or stream entry address |
| rd_col | input | CH_W | Snapshot channel or stream lane |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Read data |

## Verification
The bench builds the block with 8 channels of 8 bits, a 4-tick snapshot and 8-entry halves, so there are two receiver groups. With these sizes every snapshot cell and every stream entry can be read back and compared with a value computed from the tick number. It also takes only a few dozen ticks to wrap the ping-pong buffer, fill both halves and provoke an overrun, so the bench covers the resume-after-acknowledge path, the snapshot restart, both group selections and the reserved mode.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    CAP_OFF    = 2'd0,
    CAP_SNAP   = 2'd1,
    CAP_STREAM = 2'd2,
    CAP_RSVD   = 2'd3
  } cap_mode_e;

  typedef enum logic [1:0] {
    SP_STATUS = 2'd0,
    SP_SNAP   = 2'd1,
    SP_STREAM = 2'd2,
    SP_NONE   = 2'd3
  } rd_space_e;

  localparam int ST_DONE = 0;
  localparam int ST_RDY0 = 1;
  localparam int ST_RDY1 = 2;
  localparam int ST_OVR  = 3;
  localparam int ST_HALF = 4;
  localparam int ST_W    = 5;
endpackage

// File: rtl/cap_snapshot.sv
module cap_snapshot #(
  parameter int NCH   = 32,
  parameter int SW    = 18,
  parameter int TICKS = 64,
  localparam int W    = NCH * SW,
  localparam int AW   = $clog2(TICKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic [W-1:0]  samples,
  input  logic [AW-1:0] rd_row,
  output logic          done,
  output logic          we,
  output logic [W-1:0]  rd_word
);
  logic [AW-1:0] cnt;
  logic [W-1:0]  mem [TICKS];

  assign we = en && tick && !done;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (we) begin
      cnt <= cnt + 1'b1;
      if (cnt == AW'(TICKS - 1)) done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[cnt] <= samples;
    rd_word <= mem[rd_row];
  end
endmodule

// File: rtl/cap_stream.sv
module cap_stream #(
  parameter int NCH   = 32,
  parameter int SW    = 18,
  parameter int GRP   = 4,
  parameter int DEPTH = 256,
  localparam int W    = NCH * SW,
  localparam int RX_W = $clog2(NCH / GRP),
  localparam int IW   = $clog2(DEPTH),
  localparam int AW   = IW + 1,
  localparam int GW   = GRP * SW,
  localparam int EW   = GW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            tick,
  input  logic [W-1:0]    samples,
  input  logic            sw_state,
  input  logic [RX_W-1:0] rx_sel,
  input  logic [1:0]      ack_half,
  input  logic            ack_ovr,
  input  logic [AW-1:0]   rd_addr,
  output logic [1:0]      ready,
  output logic            ovr,
  output logic            half,
  output logic            we,
  output logic [EW-1:0]   rd_entry
);
  logic [IW-1:0] idx;
  logic [GW-1:0] grp;
  logic [1:0]    ready_nx;
  logic          blocked, last;
  logic [EW-1:0] mem [2*DEPTH];

  assign grp     = samples[int'(rx_sel) * GW +: GW];
  assign blocked = ready[half];
  assign we      = en && tick && !blocked;
  assign last    = (idx == IW'(DEPTH - 1));

  always_comb begin
    ready_nx = ready & ~ack_half;
    if (we && last) ready_nx[half] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      idx   <= '0;
      half  <= 1'b0;
      ready <= 2'b00;
      ovr   <= 1'b0;
    end else begin
      ready <= ready_nx;
      if (we) begin
        idx <= last ? '0 : idx + 1'b1;
        if (last) half <= ~half;
      end
      if (en && tick && blocked) ovr <= 1'b1;
      else if (ack_ovr)          ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[{half, idx}] <= {sw_state, grp};
    rd_entry <= mem[rd_addr];
  end
endmodule

// File: rtl/cap_readmux.sv
module cap_readmux
  import cap_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int SW   = 18,
  parameter int GRP  = 4,
  parameter int DW   = 32,
  localparam int W   = NCH * SW,
  localparam int CH_W = $clog2(NCH),
  localparam int GRP_W = $clog2(GRP),
  localparam int EW  = GRP * SW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_req,
  input  logic [1:0]      rd_space,
  input  logic [CH_W-1:0] rd_col,
  input  logic [ST_W-1:0] status,
  input  logic [W-1:0]    snap_word,
  input  logic [EW-1:0]   strm_entry,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data
);
  logic            req_q;
  rd_space_e       space_q;
  logic [CH_W-1:0] col_q;
  logic [ST_W-1:0] stat_q;
  logic [DW-1:0]   sel;
  logic [GRP_W-1:0] lane;

  assign lane = col_q[GRP_W-1:0];

  always_comb begin
    sel = '0;
    case (space_q)
      SP_STATUS: sel[ST_W-1:0] = stat_q;
      SP_SNAP:   sel[SW-1:0]   = snap_word[int'(col_q) * SW +: SW];
      SP_STREAM: begin
        sel[SW-1:0] = strm_entry[int'(lane) * SW +: SW];
        sel[SW]     = strm_entry[EW-1];
      end
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= 1'b0;
      space_q  <= SP_NONE;
      col_q    <= '0;
      stat_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      req_q    <= rd_req;
      space_q  <= rd_space_e'(rd_space);
      col_q    <= rd_col;
      stat_q   <= status;
      rd_valid <= req_q;
      if (req_q) rd_data <= sel;
    end
  end
endmodule

// File: rtl/raw_capture_buf.sv
module raw_capture_buf
  import cap_pkg::*;
#(
  parameter int NCH        = 32,
  parameter int SW         = 18,
  parameter int GRP        = 4,
  parameter int HALF_DEPTH = 256,
  parameter int SNAP_TICKS = 64,
  parameter int DW         = 32,
  localparam int RX_W  = $clog2(NCH / GRP),
  localparam int CH_W  = $clog2(NCH),
  localparam int SN_AW = $clog2(SNAP_TICKS),
  localparam int ST_AW = $clog2(HALF_DEPTH) + 1,
  localparam int ROW_W = (SN_AW > ST_AW) ? SN_AW : ST_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [RX_W-1:0]   rx_sel,
  input  logic              tick,
  input  logic [NCH*SW-1:0] samples,
  input  logic              sw_state,
  input  logic [1:0]        ack_half,
  input  logic              ack_ovr,
  input  logic              rd_req,
  input  logic [1:0]        rd_space,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [CH_W-1:0]   rd_col,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);
  localparam int EW = GRP * SW + 1;

  cap_mode_e        mode_e;
  logic             snap_en, strm_en;
  logic             snap_done, snap_we;
  logic [NCH*SW-1:0] snap_word;
  logic [1:0]       ready;
  logic             ovr, strm_half, strm_we;
  logic [EW-1:0]    strm_entry;
  logic [ST_W-1:0]  status;

  assign mode_e  = cap_mode_e'(mode);
  assign snap_en = (mode_e == CAP_SNAP);
  assign strm_en = (mode_e == CAP_STREAM);

  always_comb begin
    status          = '0;
    status[ST_DONE] = snap_done;
    status[ST_RDY0] = ready[0];
    status[ST_RDY1] = ready[1];
    status[ST_OVR]  = ovr;
    status[ST_HALF] = strm_half;
  end

  cap_snapshot #(.NCH(NCH), .SW(SW), .TICKS(SNAP_TICKS)) u_snap (
    .clk(clk), .rst(rst), .en(snap_en), .tick(tick), .samples(samples),
    .rd_row(rd_row[SN_AW-1:0]), .done(snap_done), .we(snap_we),
    .rd_word(snap_word)
  );

  cap_stream #(.NCH(NCH), .SW(SW), .GRP(GRP), .DEPTH(HALF_DEPTH)) u_strm (
    .clk(clk), .rst(rst), .en(strm_en), .tick(tick), .samples(samples),
    .sw_state(sw_state), .rx_sel(rx_sel), .ack_half(ack_half),
    .ack_ovr(ack_ovr), .rd_addr(rd_row[ST_AW-1:0]), .ready(ready),
    .ovr(ovr), .half(strm_half), .we(strm_we), .rd_entry(strm_entry)
  );

  cap_readmux #(.NCH(NCH), .SW(SW), .GRP(GRP), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_space(rd_space),
    .rd_col(rd_col), .status(status), .snap_word(snap_word),
    .strm_entry(strm_entry), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/cap_checker.sv
module cap_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       snap_done,
  input logic       snap_we,
  input logic       strm_we,
  input logic       strm_half,
  input logic [1:0] ready,
  input logic       ovr,
  input logic       ack_ovr,
  input logic       rd_req,
  input logic       rd_valid
);
  // R2: off or reserved mode writes nowhere
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 || mode == 2'd3) |-> (!snap_we && !strm_we));

  // R3: a finished snapshot is never written again
  p_snap_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    snap_done |-> !snap_we);

  // R7: a half awaiting acknowledge is never written
  p_no_overwrite_r7: assert property (@(posedge clk) disable iff (rst)
    strm_we |-> !ready[strm_half]);

  // R8: overrun holds in stream mode until acknowledged
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovr && mode == 2'd2 && !ack_ovr) |=> ovr);

  // R9: read data returns two edges after the request
  p_rd_latency_r9: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> ##1 rd_valid);

  // R3, R5: only one buffer is written per tick
  p_one_writer_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({snap_we, strm_we}));
endmodule

bind raw_capture_buf cap_checker u_chk (
  .clk(clk), .rst(rst), .mode(mode), .snap_done(snap_done),
  .snap_we(snap_we), .strm_we(strm_we), .strm_half(strm_half),
  .ready(ready), .ovr(ovr), .ack_ovr(ack_ovr), .rd_req(rd_req),
  .rd_valid(rd_valid)
);

// File: tb/sim_raw_capture_buf.sv
module sim_raw_capture_buf;
  localparam int NCH = 8, SW = 8, GRP = 4, HD = 8, ST = 4, DW = 16;
  localparam int RX_W = 1, CH_W = 3, ROW_W = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [RX_W-1:0] rx_sel = '0;
  logic tick = 1'b0, sw_state = 1'b0, ack_ovr = 1'b0, rd_req = 1'b0;
  logic [NCH*SW-1:0] samples = '0;
  logic [1:0] ack_half = 2'b00, rd_space = 2'd0;
  logic [ROW_W-1:0] rd_row = '0;
  logic [CH_W-1:0] rd_col = '0;
  logic rd_valid;
  logic [DW-1:0] rd_data;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  raw_capture_buf #(.NCH(NCH), .SW(SW), .GRP(GRP), .HALF_DEPTH(HD),
                    .SNAP_TICKS(ST), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .rx_sel(rx_sel), .tick(tick),
    .samples(samples), .sw_state(sw_state), .ack_half(ack_half),
    .ack_ovr(ack_ovr), .rd_req(rd_req), .rd_space(rd_space),
    .rd_row(rd_row), .rd_col(rd_col), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  function automatic logic [SW-1:0] chval(int seed, int c);
    return SW'(seed * 5 + c * 11 + 3);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_tick(int seed);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) samples[c*SW +: SW] = chval(seed, c);
    sw_state = seed[0];
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(string req, int sp, int row, int col, logic [31:0] exp);
    @(negedge clk);
    rd_req = 1'b1; rd_space = 2'(sp); rd_row = ROW_W'(row); rd_col = CH_W'(col);
    @(negedge clk);
    rd_req = 1'b0;
    if (rd_valid !== 1'b0) check("R9 early valid", 32'(rd_valid), 0);
    @(negedge clk);
    check("R9 valid", 32'(rd_valid), 1);
    check(req, 32'(rd_data), exp);
  endtask

  task automatic pulse_ack(logic [1:0] h, logic o);
    @(negedge clk);
    ack_half = h; ack_ovr = o;
    @(negedge clk);
    ack_half = 2'b00; ack_ovr = 1'b0;
  endtask

  // expected stream entry: lane l of group g with tag
  function automatic logic [31:0] sexp(int seed, int g, int l);
    return {23'd0, seed[0], chval(seed, g * GRP + l)};
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 valid low", 32'(rd_valid), 0);
    rd("R1 status", 0, 0, 0, 0);

    // R3 snapshot fill
    mode = 2'd1;
    for (int t = 0; t < ST - 1; t++) do_tick(10 + t);
    rd("R3 not done early", 0, 0, 0, 0);
    do_tick(10 + ST - 1);
    rd("R3 done", 0, 0, 0, 1);
    do_tick(50);
    for (int r = 0; r < ST; r++)
      for (int c = 0; c < NCH; c++) rd("R3 snapshot cell", 1, r, c, 32'(chval(10 + r, c)));

    // R2 off and reserved modes write nothing
    mode = 2'd0;
    rd("R4 done cleared", 0, 0, 0, 0);
    do_tick(60);
    mode = 2'd3;
    do_tick(61);
    rd("R2 status", 0, 0, 0, 0);
    for (int r = 0; r < ST; r++)
      for (int c = 0; c < NCH; c++) rd("R2 snapshot kept", 1, r, c, 32'(chval(10 + r, c)));

    // R4 restart
    mode = 2'd1;
    for (int t = 0; t < ST; t++) do_tick(20 + t);
    for (int r = 0; r < ST; r++)
      for (int c = 0; c < NCH; c++) rd("R4 restart cell", 1, r, c, 32'(chval(20 + r, c)));

    // R5/R6 stream, group 1
    mode = 2'd0;
    @(negedge clk);
    rx_sel = 1'b1;
    mode = 2'd2;
    for (int k = 0; k < HD; k++) do_tick(100 + k);
    rd("R6 half0 ready, half1 active", 0, 0, 0, 32'h12);
    for (int k = 0; k < HD; k++) do_tick(100 + HD + k);
    rd("R6 both ready", 0, 0, 0, 32'h06);
    for (int e = 0; e < 2 * HD; e++)
      for (int l = 0; l < GRP; l++) rd("R5 stream entry", 2, e, l, sexp(100 + e, 1, l));

    // R7 overrun and drop
    do_tick(201);
    rd("R7 overrun set", 0, 0, 0, 32'h0E);
    rd("R7 dropped", 2, 0, 0, sexp(100, 1, 0));
    pulse_ack(2'b01, 1'b0);
    rd("R6 ack clears half0", 0, 0, 0, 32'h0C);
    do_tick(300);
    for (int l = 0; l < GRP; l++) rd("R7 resume at held position", 2, 0, l, sexp(300, 1, l));
    rd("R7 next entry untouched", 2, 1, 0, sexp(101, 1, 0));
    rd("R8 overrun held", 0, 0, 0, 32'h0C);
    pulse_ack(2'b00, 1'b1);
    rd("R8 overrun cleared", 0, 0, 0, 32'h04);

    // R10 leaving stream clears flags
    mode = 2'd0;
    rd("R10 flags cleared", 0, 0, 0, 0);

    // R5 group 0, fresh start at entry 0
    rx_sel = 1'b0;
    mode = 2'd2;
    do_tick(403);
    for (int l = 0; l < GRP; l++) rd("R5 group 0", 2, 0, l, sexp(403, 0, l));
    rd("R10 position reset", 0, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule